// File: doc/BRIEF.md
# Send-Page Read Requester with Completion Writer

This block carries out a host command that asks for one page of host memory to be fetched into a local page buffer. The command names a target buffer, a length in 8-byte words (qwords) and a start address. The block cuts the transfer into read requests. No request crosses a 32-qword aligned boundary, and no request is longer than a programmable cap. Each request is tagged with the buffer number. Returned completion beats are written into the buffer one qword at a time. When the last qword of the page has been written, a single-cycle done pulse tells the buffer that the page is complete.

Only one request is in flight at a time. The next piece is issued only after every beat of the current piece has come back. The read request port uses a valid/ready handshake. `req_valid` stays high with stable fields until a cycle in which `req_ready` is also high, and it is low in the next cycle. The completion input has no back-pressure: every beat offered with `cpl_valid` high is taken or dropped in that cycle. The buffer write port is a plain write strobe.

Top module: `sprq_send_page`

## Requirements
- R1: A command is accepted only in idle, on a cycle with `cmd_wr` high, `cmd_addr[4:3]` equal to 2'b01 and a nonzero length in `cmd_addr[18:10]`. The buffer index comes from `cmd_addr[8:5]` and the qword start address from `cmd_data[63:3]`. A command with any other opcode, or with zero length, starts no request.
- R2: The first request's `req_valid` is low after the edge that samples the command and after the next edge, and it is high after the third edge.
- R3: Each request length is the smallest of three values: the qwords still to fetch, 32 minus (address mod 32), and 16 shifted left by `max_rd_sel`. Each request starts where the previous one ended.
- R4: `req_tag` equals the buffer index zero-extended to 5 bits.
- R5: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_len` and `req_tag` hold. After a cycle with both high, `req_valid` is low.
- R6: A completion beat whose tag equals the current tag, arriving after the request was accepted and while beats are still owed, gives `buf_we` high in the next cycle with that data and the buffer index on `buf_sel`. A beat with any other tag, or a beat when nothing is owed, gives no write.
- R7: After the last beat of a piece that is not the final one, `req_valid` is low one cycle later and high two cycles later. No request is raised while beats are owed.
- R8: One cycle after the final beat of the page is written, `buf_wr_done` is high for exactly one cycle, with `req_valid` and `buf_we` low.
- R9: A send command that arrives while a page is in progress is ignored. No extra request follows the page.
- R10: In reset, and right after it, `req_valid`, `buf_we` and `buf_wr_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host command write strobe |
| cmd_addr | input | 19 | Command address: opcode [4:3], buffer [8:5], length [18:10] |
| cmd_data | input | 64 | Command data; [63:3] is the qword start address |
| max_rd_sel | input | 3 | Read cap select: 16 << value qwords |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 61 | Request qword address |
| req_len | output | 9 | Request length in qwords |
| req_tag | output | 5 | Request tag (buffer index) |
| cpl_valid | input | 1 | Completion beat valid |
| cpl_data | input | 64 | Completion beat data |
| cpl_tag | input | 5 | Completion beat tag |
| buf_we | output | 1 | Buffer write enable |
| buf_sel | output | 4 | Buffer select |
| buf_wdata | output | 64 | Buffer write data |
| buf_wr_done | output | 1 | Page complete pulse |

## Verification
Internal faults show up at the ports within a few cycles. A wrong remaining count or current address appears as a wrong `req_addr` or `req_len` on the next request, or as a done pulse that comes early or never comes. A broken beat counter shows as a request raised while beats are still owed, or as writes accepted after the piece has ended, at the latest two cycles after the beat that was miscounted. A stuck state machine shows as a missing request within three cycles of a command, or as a request that never drops after its handshake.

// File: rtl/sprq_pkg.sv
package sprq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLAN,
    ST_ISSUE,
    ST_REQ,
    ST_WAIT,
    ST_FIN
  } rq_state_e;

endpackage

// File: rtl/sprq_chunk_calc.sv
module sprq_chunk_calc #(
  parameter int ADDR_W  = 61,
  parameter int LEN_W   = 9,
  parameter int BND_QW  = 32,
  parameter int BASE_QW = 16,
  parameter int MAXSZ_W = 3
) (
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [LEN_W-1:0]   remain,
  input  logic [MAXSZ_W-1:0] max_sel,
  output logic [LEN_W-1:0]   chunk_len
);
  localparam int BND_W = $clog2(BND_QW);
  localparam int CAP_W = $clog2(BASE_QW) + (1 << MAXSZ_W);
  localparam int CMP_W = (CAP_W > LEN_W) ? ((CAP_W > BND_W + 1) ? CAP_W : BND_W + 1)
                                         : ((LEN_W > BND_W + 1) ? LEN_W : BND_W + 1);

  logic [CMP_W-1:0] to_bnd, cap, rem_x, m1, m2;

  always_comb begin
    to_bnd = CMP_W'(BND_QW) - CMP_W'(cur_addr[BND_W-1:0]);
    cap    = CMP_W'(BASE_QW) << max_sel;
    rem_x  = CMP_W'(remain);
    m1     = (rem_x < to_bnd) ? rem_x : to_bnd;
    m2     = (m1 < cap) ? m1 : cap;
    chunk_len = m2[LEN_W-1:0];
  end
endmodule

// File: rtl/sprq_cpl_sink.sv
module sprq_cpl_sink #(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 5,
  parameter int BUF_W  = 4,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [LEN_W-1:0]  arm_len,
  input  logic              accept_en,
  input  logic [TAG_W-1:0]  cur_tag,
  input  logic [BUF_W-1:0]  buf_idx,
  input  logic              cpl_valid,
  input  logic [DATA_W-1:0] cpl_data,
  input  logic [TAG_W-1:0]  cpl_tag,
  output logic              last_beat,
  output logic              buf_we,
  output logic [BUF_W-1:0]  buf_sel,
  output logic [DATA_W-1:0] buf_wdata
);
  logic [LEN_W-1:0] beats_left;
  logic             hit;

  assign hit       = cpl_valid && accept_en && (cpl_tag == cur_tag) && (beats_left != '0);
  assign last_beat = hit && (beats_left == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats_left <= '0;
      buf_we     <= 1'b0;
      buf_sel    <= '0;
      buf_wdata  <= '0;
    end else begin
      buf_we <= hit;
      if (arm) begin
        beats_left <= arm_len;
      end else if (hit) begin
        beats_left <= beats_left - LEN_W'(1);
      end
      if (hit) begin
        buf_wdata <= cpl_data;
        buf_sel   <= buf_idx;
      end
    end
  end
endmodule

// File: rtl/sprq_send_page.sv
module sprq_send_page #(
  parameter int DATA_W  = 64,
  parameter int LEN_W   = 9,
  parameter int BUF_W   = 4,
  parameter int TAG_W   = 5,
  parameter int BND_QW  = 32,
  parameter int BASE_QW = 16,
  parameter int MAXSZ_W = 3,
  parameter int OPC_LSB = 3,
  parameter int BUF_LSB = 5,
  parameter int LEN_LSB = 10,
  parameter logic [1:0] OPC_SEND = 2'b01
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_wr,
  input  logic [LEN_LSB+LEN_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]         cmd_data,
  input  logic [MAXSZ_W-1:0]        max_rd_sel,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [DATA_W-4:0]         req_addr,
  output logic [LEN_W-1:0]          req_len,
  output logic [TAG_W-1:0]          req_tag,
  input  logic                      cpl_valid,
  input  logic [DATA_W-1:0]         cpl_data,
  input  logic [TAG_W-1:0]          cpl_tag,
  output logic                      buf_we,
  output logic [BUF_W-1:0]          buf_sel,
  output logic [DATA_W-1:0]         buf_wdata,
  output logic                      buf_wr_done
);
  import sprq_pkg::*;

  localparam int ADDR_W = DATA_W - 3;

  rq_state_e         state;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [BUF_W-1:0]  buf_idx;
  logic [LEN_W-1:0]  chunk_q;
  logic [LEN_W-1:0]  chunk_len;
  logic [TAG_W-1:0]  cur_tag;
  logic              cmd_go;
  logic              last_beat;
  logic              arm;

  assign cur_tag = TAG_W'(buf_idx);
  assign arm     = (state == ST_ISSUE);
  assign cmd_go  = cmd_wr && (state == ST_IDLE)
                && (cmd_addr[OPC_LSB+1:OPC_LSB] == OPC_SEND)
                && (cmd_addr[LEN_LSB+LEN_W-1:LEN_LSB] != '0);

  sprq_chunk_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BND_QW(BND_QW),
    .BASE_QW(BASE_QW), .MAXSZ_W(MAXSZ_W)
  ) u_calc (
    .cur_addr (cur_addr),
    .remain   (remain),
    .max_sel  (max_rd_sel),
    .chunk_len(chunk_len)
  );

  sprq_cpl_sink #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .BUF_W(BUF_W), .LEN_W(LEN_W)
  ) u_sink (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .arm_len  (chunk_q),
    .accept_en(state == ST_WAIT),
    .cur_tag  (cur_tag),
    .buf_idx  (buf_idx),
    .cpl_valid(cpl_valid),
    .cpl_data (cpl_data),
    .cpl_tag  (cpl_tag),
    .last_beat(last_beat),
    .buf_we   (buf_we),
    .buf_sel  (buf_sel),
    .buf_wdata(buf_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur_addr    <= '0;
      remain      <= '0;
      buf_idx     <= '0;
      chunk_q     <= '0;
      req_valid   <= 1'b0;
      req_addr    <= '0;
      req_len     <= '0;
      req_tag     <= '0;
      buf_wr_done <= 1'b0;
    end else begin
      buf_wr_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_go) begin
            cur_addr <= cmd_data[DATA_W-1:3];
            remain   <= cmd_addr[LEN_LSB+LEN_W-1:LEN_LSB];
            buf_idx  <= cmd_addr[BUF_LSB+BUF_W-1:BUF_LSB];
            state    <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          chunk_q <= chunk_len;
          state   <= ST_ISSUE;
        end
        ST_ISSUE: begin
          req_valid <= 1'b1;
          req_addr  <= cur_addr;
          req_len   <= chunk_q;
          req_tag   <= cur_tag;
          cur_addr  <= cur_addr + ADDR_W'(chunk_q);
          remain    <= remain - chunk_q;
          state     <= ST_REQ;
        end
        ST_REQ: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (last_beat) begin
            state <= (remain == '0) ? ST_FIN : ST_PLAN;
          end
        end
        ST_FIN: begin
          buf_wr_done <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sprq_checker.sv
module sprq_checker #(
  parameter int DATA_W  = 64,
  parameter int LEN_W   = 9,
  parameter int BUF_W   = 4,
  parameter int TAG_W   = 5,
  parameter int BND_QW  = 32,
  parameter int BASE_QW = 16,
  parameter int MAXSZ_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [MAXSZ_W-1:0]   max_rd_sel,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [DATA_W-4:0]    req_addr,
  input logic [LEN_W-1:0]     req_len,
  input logic [TAG_W-1:0]     req_tag,
  input logic                 buf_we,
  input logic [BUF_W-1:0]     buf_sel,
  input logic                 buf_wr_done
);
  localparam int BND_W = $clog2(BND_QW);

  logic [15:0] owed;

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else owed <= owed + ((req_valid && req_ready) ? 16'(req_len) : 16'd0)
                      - (buf_we ? 16'd1 : 16'd0);
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_tag)); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid); // R5
  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_addr[BND_W-1:0]) + int'(req_len) <= BND_QW)); // R3
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (int'(req_len) <= (BASE_QW << max_rd_sel))); // R3
  AST_SEL_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> TAG_W'(buf_sel) == req_tag); // R4
  AST_WE_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> owed != '0); // R6
  AST_NO_REQ_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> owed == '0); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_done |=> !buf_wr_done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_done |-> !req_valid && !buf_we && owed == '0); // R8
endmodule

bind sprq_send_page sprq_checker #(
  .DATA_W(DATA_W), .LEN_W(LEN_W), .BUF_W(BUF_W), .TAG_W(TAG_W),
  .BND_QW(BND_QW), .BASE_QW(BASE_QW), .MAXSZ_W(MAXSZ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .max_rd_sel(max_rd_sel),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_len(req_len), .req_tag(req_tag), .buf_we(buf_we),
  .buf_sel(buf_sel), .buf_wr_done(buf_wr_done)
);

// File: tb/tb_sprq_send_page.sv
`timescale 1ns/100ps
module tb_sprq_send_page;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [18:0] cmd_addr = '0;
  logic [63:0] cmd_data = '0;
  logic [2:0]  max_rd_sel = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [60:0] req_addr;
  logic [8:0]  req_len;
  logic [4:0]  req_tag;
  logic        cpl_valid = 1'b0;
  logic [63:0] cpl_data = '0;
  logic [4:0]  cpl_tag = '0;
  logic        buf_we;
  logic [3:0]  buf_sel;
  logic [63:0] buf_wdata;
  logic        buf_wr_done;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  sprq_send_page dut (.*);

  typedef struct packed {
    logic [60:0] start;
    logic [8:0]  len;
    logic [3:0]  bufi;
    logic [2:0]  msel;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{61'd31,  9'd3,  4'd2,  3'd3},
    '{61'd0,   9'd40, 4'd5,  3'd0},
    '{61'd100, 9'd70, 4'd7,  3'd2},
    '{61'd5,   9'd1,  4'd15, 3'd1},
    '{61'd64,  9'd33, 4'd0,  3'd4}
  };

  task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send_cmd(input logic [1:0] opc, input logic [60:0] start,
                          input logic [8:0] len, input logic [3:0] bufi);
    cmd_wr = 1'b1;
    cmd_addr = '0;
    cmd_addr[4:3] = opc;
    cmd_addr[8:5] = bufi;
    cmd_addr[18:10] = len;
    cmd_data = {start, 3'b000};
    tick();
    cmd_wr = 1'b0;
    cmd_addr = '0;
    cmd_data = '0;
  endtask

  initial begin : watchdog
    #1000000;
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int cur, rem, cap, bnd, elen;
    tick();
    chk("R10", "req_valid in reset", 64'(req_valid), 0);
    chk("R10", "buf_we in reset", 64'(buf_we), 0);
    chk("R10", "done in reset", 64'(buf_wr_done), 0);
    rst_n = 1'b1;
    tick();
    chk("R10", "req_valid after reset", 64'(req_valid), 0);

    for (int v = 0; v < 5; v++) begin
      max_rd_sel = VECS[v].msel;
      send_cmd(2'b01, VECS[v].start, VECS[v].len, VECS[v].bufi);
      chk("R2", "valid after edge 1", 64'(req_valid), 0);
      tick();
      chk("R2", "valid after edge 2", 64'(req_valid), 0);
      tick();
      chk("R2", "valid after edge 3", 64'(req_valid), 1);
      cur = int'(VECS[v].start);
      rem = int'(VECS[v].len);
      while (rem > 0) begin
        cap  = 16 << VECS[v].msel;
        bnd  = 32 - (cur % 32);
        elen = rem;
        if (bnd < elen) elen = bnd;
        if (cap < elen) elen = cap;
        chk("R3", "req_addr", 64'(req_addr), 64'(cur));
        chk("R3", "req_len", 64'(req_len), 64'(elen));
        chk("R4", "req_tag", 64'(req_tag), 64'(VECS[v].bufi));
        if (v == 0) begin
          tick();
          chk("R5", "valid held", 64'(req_valid), 1);
          chk("R5", "addr held", 64'(req_addr), 64'(cur));
        end
        req_ready = 1'b1;
        tick();
        req_ready = 1'b0;
        chk("R5", "valid after handshake", 64'(req_valid), 0);
        cpl_valid = 1'b1;
        cpl_tag = {1'b1, VECS[v].bufi};
        cpl_data = 64'hDEAD;
        tick();
        cpl_valid = 1'b0;
        chk("R6", "wrong tag ignored", 64'(buf_we), 0);
        if (v == 0 && cur == 31) begin
          send_cmd(2'b01, 61'd200, 9'd4, 4'd9);
          chk("R9", "busy cmd no write", 64'(buf_we), 0);
        end
        for (int b = 0; b < elen; b++) begin
          cpl_valid = 1'b1;
          cpl_tag = {1'b0, VECS[v].bufi};
          cpl_data = {32'hC0DE0000 | 32'(v), 32'(cur + b)};
          tick();
          chk("R6", "buf_we", 64'(buf_we), 1);
          chk("R6", "buf_wdata", buf_wdata, {32'hC0DE0000 | 32'(v), 32'(cur + b)});
          chk("R6", "buf_sel", 64'(buf_sel), 64'(VECS[v].bufi));
          if (b != elen - 1) chk("R7", "no req while owed", 64'(req_valid), 0);
        end
        cpl_valid = 1'b0;
        cur += elen;
        rem -= elen;
        tick();
        if (rem > 0) begin
          chk("R7", "valid 1 cycle after last beat", 64'(req_valid), 0);
          chk("R8", "no early done", 64'(buf_wr_done), 0);
          tick();
          chk("R7", "valid 2 cycles after last beat", 64'(req_valid), 1);
        end else begin
          chk("R8", "done pulse", 64'(buf_wr_done), 1);
          chk("R8", "no req at done", 64'(req_valid), 0);
          chk("R8", "no write at done", 64'(buf_we), 0);
          tick();
          chk("R8", "done single cycle", 64'(buf_wr_done), 0);
        end
      end
      for (int k = 0; k < 4; k++) begin
        tick();
        chk("R9", "no request after page", 64'(req_valid), 0);
      end
    end

    // directed: other opcode ignored
    send_cmd(2'b10, 61'd8, 9'd4, 4'd3);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R1", "other opcode no request", 64'(req_valid), 0);
    end
    // directed: zero length ignored
    send_cmd(2'b01, 61'd8, 9'd0, 4'd3);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R1", "zero length no request", 64'(req_valid), 0);
    end
    // directed: stray completion in idle
    cpl_valid = 1'b1;
    cpl_tag = 5'd3;
    cpl_data = 64'h1234;
    tick();
    cpl_valid = 1'b0;
    tick();
    chk("R6", "idle completion ignored", 64'(buf_we), 0);
    // directed: valid command still works afterwards
    max_rd_sel = 3'd0;
    send_cmd(2'b01, 61'd30, 9'd2, 4'd3);
    tick();
    tick();
    chk("R1", "accepted after ignored ones", 64'(req_valid), 1);
    chk("R3", "req_len at boundary", 64'(req_len), 2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule